// File: doc/BRIEF.md
# Floppy Controller Command-Phase Sequencer

This block sits behind the byte-wide data and status registers of a floppy disk controller. It runs the host exchange through three phases. In the command phase the host writes an opcode and then its parameter bytes. In the execution phase a data transfer streams bytes without DMA. In the result phase the host reads status bytes back. The opcode tells the block how many parameter bytes follow. Once the last one arrives, the block acts on the command at once.

Only commands that touch registers are executed in full. Read and write data transfers are stubbed as a fixed-length byte stream through a one-sector buffer, which wraps when a transfer is longer than a sector. The host polls the status byte to learn whether the data register expects a write or a read. An interrupt output flags seek completion and the end of a transfer. Reading the last result byte of any command drops that interrupt.

Top module: `fdc_seq`

## Requirements
- R1: A synchronous reset (rst_n low at a clock edge) forces the command phase with position 0, `irq` low, `proto_err` low and `status` equal to 0x80.
- R2: `status` carries request-for-master in bit 7, direction-to-host in bit 6, non-DMA execution in bit 5 and command-busy in bit 4, with bits 3..0 zero. `phase_o` reads 1 for command, 2 for execution and 3 for result, and never 0 outside reset. In the command phase `status` is 0x80 until an opcode that takes parameters is written, and 0x90 after it.
- R3: The opcode decodes to a parameter count as follows. Read data (low 5 bits 00110) and write data (low 6 bits 000101) take 8 parameters. Specify (0x03) and seek (0x0F) take 2. Sense-interrupt (0x08), version (0x10), part-ID (0x18) and lock (low 7 bits 0010100) take none. The command executes on the cycle its last byte is written.
- R4: In the result phase `status` is 0xD0 and `rd_byte` presents the result bytes in order, one per read strobe. Reading the last byte returns the block to the command phase with `status` 0x80 and drives `irq` low.
- R5: Version returns one byte equal to parameter VERSION_ID. Part-ID returns one byte 0x41. Lock returns one byte equal to opcode bit 7 shifted left by 4.
- R6: An opcode that matches none of R3, or a sense-interrupt issued while `irq` is low, returns one result byte 0x80.
- R7: Seek returns no result bytes. It stores its last parameter as the current track and raises `irq`. A sense-interrupt issued while `irq` is high returns two bytes, 0x20 ORed with the drive number (bits 1..0 of the first parameter of the seek), then the track, and lowers `irq`.
- R8: Read and write data enter the execution phase with `status` 0xF0 (read) or 0xB0 (write) and move XFER_LEN bytes. They then enter the result phase with seven bytes: the drive number, 0x00, 0x00, then parameters 2 through 5 of the command. On that entry they raise `irq`.
- R9: Byte k of a transfer uses buffer slot k modulo SECTOR_LEN, so a read after a write returns the last bytes written to each slot.
- R10: A data read in the command phase, a data write in the result phase, and an access against the direction shown in bit 6 during execution are all ignored: phase, position and output bytes stay unchanged. Each such access sets `proto_err`, which stays set until reset.
- R11: Specify consumes its two parameters and returns straight to the command phase with no result bytes and no change to `irq`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_stb | input | 1 | Data register write strobe |
| wr_byte | input | 8 | Byte written by the host |
| rd_stb | input | 1 | Data register read strobe; advances the read position |
| rd_byte | output | 8 | Byte currently presented to the host |
| status | output | 8 | Main status flags |
| phase_o | output | 2 | Current phase code |
| irq | output | 1 | Interrupt request |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The bench builds the block with SECTOR_LEN = 8, XFER_LEN = 12 and VERSION_ID = 0x90. With these values a single 12-byte write already overwrites slots 0..3 of the buffer. The following read therefore returns a mix of the second pass (slots 0..3) and the first pass (slots 4..7), which makes wrapping visible at the ports. The 8-slot buffer also takes the power-of-two index path, while the 12-byte length exercises a transfer counter that is wider than the slot index.

// File: rtl/fdc_seq_pkg.sv
package fdc_seq_pkg;

   typedef enum logic [1:0] {
      PH_RECON = 2'd0,
      PH_CMD   = 2'd1,
      PH_EXEC  = 2'd2,
      PH_RES   = 2'd3
   } phase_t;

   typedef enum logic [3:0] {
      K_BAD,
      K_READ,
      K_WRITE,
      K_SPECIFY,
      K_SEEK,
      K_SENSEI,
      K_VERSION,
      K_PARTID,
      K_LOCK
   } cmd_kind_t;

   localparam int MAX_PARAMS  = 8;
   localparam int MAX_RESULTS = 7;
   localparam int PCNT_W      = 4;

   localparam logic [7:0] ST0_INVALID  = 8'h80;
   localparam logic [7:0] ST0_SEEK_END = 8'h20;
   localparam logic [7:0] PART_ID_BYTE = 8'h41;

endpackage

// File: rtl/fdc_cmd_decode.sv
module fdc_cmd_decode
   import fdc_seq_pkg::*;
(
   input  logic [7:0]        opcode,
   output cmd_kind_t         kind,
   output logic [PCNT_W-1:0] nparams
);

   always_comb begin
      if ((opcode & 8'h1f) == 8'h06)       kind = K_READ;
      else if ((opcode & 8'h3f) == 8'h05)  kind = K_WRITE;
      else if (opcode == 8'h03)            kind = K_SPECIFY;
      else if (opcode == 8'h0f)            kind = K_SEEK;
      else if (opcode == 8'h08)            kind = K_SENSEI;
      else if (opcode == 8'h10)            kind = K_VERSION;
      else if (opcode == 8'h18)            kind = K_PARTID;
      else if ((opcode & 8'h7f) == 8'h14)  kind = K_LOCK;
      else                                 kind = K_BAD;
   end

   always_comb begin
      unique case (kind)
         K_READ, K_WRITE:  nparams = PCNT_W'(MAX_PARAMS);
         K_SPECIFY, K_SEEK: nparams = PCNT_W'(2);
         default:          nparams = '0;
      endcase
   end

endmodule

// File: rtl/fdc_sector_buf.sv
module fdc_sector_buf #(
   parameter int SECTOR_LEN = 512,
   parameter int POS_W      = 5
) (
   input  logic             clk,
   input  logic             we,
   input  logic [POS_W-1:0] pos,
   input  logic [7:0]       wdata,
   output logic [7:0]       rdata
);

   localparam int IDX_W = (SECTOR_LEN > 1) ? $clog2(SECTOR_LEN) : 1;
   localparam bit POW2  = ((SECTOR_LEN & (SECTOR_LEN - 1)) == 0);

   logic [IDX_W-1:0] idx;
   logic [7:0]       mem [SECTOR_LEN];

   if (SECTOR_LEN < 2) begin : g_bad_len
      $error("fdc_sector_buf: SECTOR_LEN must be at least 2");
   end

   if (POW2) begin : g_pow2
      assign idx = IDX_W'({{IDX_W{1'b0}}, pos});
   end else begin : g_mod
      assign idx = IDX_W'(32'(pos) % 32'(SECTOR_LEN));
   end

   always_ff @(posedge clk) begin
      if (we) mem[idx] <= wdata;
   end

   assign rdata = mem[idx];

endmodule

// File: rtl/fdc_seq.sv
module fdc_seq
   import fdc_seq_pkg::*;
#(
   parameter int         SECTOR_LEN = 512,
   parameter int         XFER_LEN   = 16,
   parameter logic [7:0] VERSION_ID = 8'h90
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_stb,
   input  logic [7:0] wr_byte,
   input  logic       rd_stb,
   output logic [7:0] rd_byte,
   output logic [7:0] status,
   output logic [1:0] phase_o,
   output logic       irq,
   output logic       proto_err
);

   localparam int LEN_MAX = (XFER_LEN > MAX_PARAMS + 1) ? XFER_LEN : MAX_PARAMS + 1;
   localparam int POS_W   = $clog2(LEN_MAX + 1);

   if (XFER_LEN < 1) begin : g_bad_xfer
      $error("fdc_seq: XFER_LEN must be at least 1");
   end

   phase_t           phase_q, phase_d;
   logic [POS_W-1:0] pos_q, pos_d, len_q, len_d;
   logic             busy_q, busy_d, dio_q, dio_d, ndma_q, ndma_d;
   logic             irq_q, irq_d, err_q, err_d;
   logic [7:0]       track_q, track_d, st0_q, st0_d;
   cmd_kind_t        kind_q, kind_d;
   logic [7:0]       prm_q [MAX_PARAMS + 1];
   logic [7:0]       res_q [MAX_RESULTS];
   logic [7:0]       res_d [MAX_RESULTS];
   logic             prm_we;

   cmd_kind_t         dec_kind, kind_now;
   logic [PCNT_W-1:0] dec_np;
   logic [POS_W-1:0]  len_now, pos_nx, res_n;
   logic              rd_ok, wr_ok, bad, enter_cmd, enter_res;
   logic              buf_we;
   logic [7:0]        buf_rdata;

   fdc_cmd_decode u_dec (
      .opcode  (wr_byte),
      .kind    (dec_kind),
      .nparams (dec_np)
   );

   fdc_sector_buf #(
      .SECTOR_LEN (SECTOR_LEN),
      .POS_W      (POS_W)
   ) u_buf (
      .clk   (clk),
      .we    (buf_we),
      .pos   (pos_q),
      .wdata (wr_byte),
      .rdata (buf_rdata)
   );

   assign kind_now = (pos_q == '0) ? dec_kind : kind_q;
   assign len_now  = (pos_q == '0) ? POS_W'(dec_np) + POS_W'(1) : len_q;
   assign pos_nx   = pos_q + POS_W'(1);

   assign rd_ok  = (phase_q == PH_RES) || (phase_q == PH_EXEC && dio_q);
   assign wr_ok  = (phase_q == PH_CMD) || (phase_q == PH_EXEC && !dio_q);
   assign bad    = (rd_stb && !rd_ok) || (wr_stb && !wr_ok);
   assign buf_we = wr_stb && !bad && phase_q == PH_EXEC;

   always_comb begin
      phase_d   = phase_q;
      pos_d     = pos_q;
      len_d     = len_q;
      busy_d    = busy_q;
      dio_d     = dio_q;
      ndma_d    = ndma_q;
      irq_d     = irq_q;
      err_d     = err_q;
      track_d   = track_q;
      st0_d     = st0_q;
      kind_d    = kind_q;
      res_d     = res_q;
      res_n     = POS_W'(1);
      prm_we    = 1'b0;
      enter_cmd = 1'b0;
      enter_res = 1'b0;

      if (bad) begin
         err_d = 1'b1;
      end else begin
         unique case (phase_q)
            PH_CMD: if (wr_stb) begin
               prm_we = 1'b1;
               pos_d  = pos_nx;
               if (pos_q == '0) begin
                  kind_d = dec_kind;
                  len_d  = len_now;
                  busy_d = 1'b1;
               end
               if (pos_nx == len_now) begin
                  unique case (kind_now)
                     K_READ, K_WRITE: begin
                        phase_d = PH_EXEC;
                        pos_d   = '0;
                        len_d   = POS_W'(XFER_LEN);
                        ndma_d  = 1'b1;
                        dio_d   = (kind_now == K_READ);
                     end
                     K_SPECIFY: enter_cmd = 1'b1;
                     K_SEEK: begin
                        track_d   = wr_byte;
                        st0_d     = ST0_SEEK_END | {6'b0, prm_q[1][1:0]};
                        irq_d     = 1'b1;
                        enter_cmd = 1'b1;
                     end
                     K_SENSEI: begin
                        enter_res = 1'b1;
                        if (irq_q) begin
                           res_d[0] = st0_q;
                           res_d[1] = track_q;
                           res_n    = POS_W'(2);
                           irq_d    = 1'b0;
                        end else begin
                           res_d[0] = ST0_INVALID;
                        end
                     end
                     K_VERSION: begin
                        res_d[0]  = VERSION_ID;
                        enter_res = 1'b1;
                     end
                     K_PARTID: begin
                        res_d[0]  = PART_ID_BYTE;
                        enter_res = 1'b1;
                     end
                     K_LOCK: begin
                        res_d[0]  = {3'b0, wr_byte[7], 4'b0};
                        enter_res = 1'b1;
                     end
                     default: begin
                        res_d[0]  = ST0_INVALID;
                        enter_res = 1'b1;
                     end
                  endcase
               end
            end
            PH_EXEC: if (rd_stb || wr_stb) begin
               pos_d = pos_nx;
               if (pos_nx == len_q) begin
                  res_d[0]  = {6'b0, prm_q[1][1:0]};
                  res_d[1]  = 8'h00;
                  res_d[2]  = 8'h00;
                  res_d[3]  = prm_q[2];
                  res_d[4]  = prm_q[3];
                  res_d[5]  = prm_q[4];
                  res_d[6]  = prm_q[5];
                  res_n     = POS_W'(MAX_RESULTS);
                  irq_d     = 1'b1;
                  enter_res = 1'b1;
               end
            end
            PH_RES: if (rd_stb) begin
               pos_d = pos_nx;
               if (pos_nx == len_q) begin
                  irq_d     = 1'b0;
                  enter_cmd = 1'b1;
               end
            end
            default: enter_cmd = 1'b1;
         endcase
      end

      if (enter_cmd) begin
         phase_d = PH_CMD;
         pos_d   = '0;
         len_d   = POS_W'(1);
         busy_d  = 1'b0;
         dio_d   = 1'b0;
         ndma_d  = 1'b0;
      end
      if (enter_res) begin
         phase_d = PH_RES;
         pos_d   = '0;
         len_d   = res_n;
         busy_d  = 1'b1;
         dio_d   = 1'b1;
         ndma_d  = 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_CMD;
         pos_q   <= '0;
         len_q   <= POS_W'(1);
         busy_q  <= 1'b0;
         dio_q   <= 1'b0;
         ndma_q  <= 1'b0;
         irq_q   <= 1'b0;
         err_q   <= 1'b0;
         track_q <= '0;
         st0_q   <= '0;
         kind_q  <= K_BAD;
         for (int i = 0; i < MAX_RESULTS; i++) res_q[i] <= '0;
         for (int i = 0; i <= MAX_PARAMS; i++) prm_q[i] <= '0;
      end else begin
         phase_q <= phase_d;
         pos_q   <= pos_d;
         len_q   <= len_d;
         busy_q  <= busy_d;
         dio_q   <= dio_d;
         ndma_q  <= ndma_d;
         irq_q   <= irq_d;
         err_q   <= err_d;
         track_q <= track_d;
         st0_q   <= st0_d;
         kind_q  <= kind_d;
         res_q   <= res_d;
         if (prm_we && pos_q <= POS_W'(MAX_PARAMS)) prm_q[pos_q] <= wr_byte;
      end
   end

   always_comb begin
      if (phase_q == PH_RES)              rd_byte = res_q[pos_q[2:0]];
      else if (phase_q == PH_EXEC && dio_q) rd_byte = buf_rdata;
      else                                rd_byte = 8'h00;
   end

   assign status    = {phase_q != PH_RECON, dio_q, ndma_q, busy_q, 4'b0000};
   assign phase_o   = phase_q;
   assign irq       = irq_q;
   assign proto_err = err_q;

endmodule

// File: rtl/fdc_seq_chk.sv
module fdc_seq_chk #(
   parameter int POS_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             wr_stb,
   input logic             rd_stb,
   input logic [7:0]       status,
   input logic [1:0]       phase_o,
   input logic             irq,
   input logic             proto_err,
   input logic [POS_W-1:0] pos_q,
   input logic [POS_W-1:0] len_q
);

   logic was_rst;

   always_ff @(posedge clk) begin
      was_rst <= !rst_n;
      if (rst_n && was_rst) begin
         a_r1_reset_state: assert (phase_o == 2'd1 && status == 8'h80 && !irq && !proto_err)
            else $error("reset state wrong");
      end
   end

   a_r2_phase_legal: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o != 2'd0);

   a_r2_cmd_flags: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 2'd1 |-> status[7:5] == 3'b100);

   a_r4_result_flags: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 2'd3 |-> status == 8'hD0);

   a_r4_last_read: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 2'd3 && rd_stb && !wr_stb && (pos_q + 1'b1) == len_q)
      |=> (phase_o == 2'd1 && status == 8'h80 && !irq));

   a_r8_exec_flags: assert property (@(posedge clk) disable iff (!rst_n)
      phase_o == 2'd2 |-> (status[7] && status[5] && status[4]));

   a_r10_result_write: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 2'd3 && wr_stb) |=> (phase_o == 2'd3 && pos_q == $past(pos_q) && proto_err));

   a_r10_command_read: assert property (@(posedge clk) disable iff (!rst_n)
      (phase_o == 2'd1 && rd_stb) |=> (phase_o == 2'd1 && pos_q == $past(pos_q) && proto_err));

   a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      proto_err |=> proto_err);

endmodule

bind fdc_seq fdc_seq_chk #(.POS_W(POS_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .status    (status),
   .phase_o   (phase_o),
   .irq       (irq),
   .proto_err (proto_err),
   .pos_q     (pos_q),
   .len_q     (len_q)
);

// File: tb/fdc_seq_test.sv
module fdc_seq_test;

   localparam int CLK_PERIOD = 10;
   localparam int SECT = 8;
   localparam int XLEN = 12;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0;
   logic [7:0] wr_byte = 8'h00;
   logic       rd_stb = 1'b0;
   logic [7:0] rd_byte, status;
   logic [1:0] phase_o;
   logic       irq, proto_err;

   int n_chk = 0;
   int n_bad = 0;

   always #(CLK_PERIOD / 2) clk = ~clk;

   fdc_seq #(.SECTOR_LEN(SECT), .XFER_LEN(XLEN), .VERSION_ID(8'h90)) uut (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_stb    (wr_stb),
      .wr_byte   (wr_byte),
      .rd_stb    (rd_stb),
      .rd_byte   (rd_byte),
      .status    (status),
      .phase_o   (phase_o),
      .irq       (irq),
      .proto_err (proto_err)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] b);
      wr_byte = b;
      wr_stb  = 1'b1;
      @(negedge clk);
      wr_stb  = 1'b0;
   endtask

   task automatic rd(output logic [7:0] b);
      b      = rd_byte;
      rd_stb = 1'b1;
      @(negedge clk);
      rd_stb = 1'b0;
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
   endtask

   task automatic t_reset();
      chk("R1 status", status, 8'h80);
      chk("R1 phase", {6'b0, phase_o}, 8'h01);
      chk("R1 irq", {7'b0, irq}, 8'h00);
      chk("R1 err", {7'b0, proto_err}, 8'h00);
   endtask

   task automatic t_version();
      logic [7:0] b;
      wr(8'h10);
      chk("R4 result status", status, 8'hD0);
      chk("R2 phase result", {6'b0, phase_o}, 8'h03);
      rd(b);
      chk("R5 version byte", b, 8'h90);
      chk("R4 back to command", status, 8'h80);
   endtask

   task automatic t_partid_lock();
      logic [7:0] b;
      wr(8'h18); rd(b);
      chk("R5 part id", b, 8'h41);
      wr(8'h94); rd(b);
      chk("R5 lock set", b, 8'h10);
      wr(8'h14); rd(b);
      chk("R5 lock clear", b, 8'h00);
      chk("R4 command after lock", {6'b0, phase_o}, 8'h01);
   endtask

   task automatic t_invalid();
      logic [7:0] b;
      wr(8'hFF); rd(b);
      chk("R6 unknown opcode", b, 8'h80);
      chk("R6 single byte", status, 8'h80);
      wr(8'h08); rd(b);
      chk("R6 sense without irq", b, 8'h80);
      chk("R6 sense single byte", status, 8'h80);
   endtask

   task automatic t_specify();
      wr(8'h03);
      chk("R2 busy after opcode", status, 8'h90);
      chk("R3 waits for params", {6'b0, phase_o}, 8'h01);
      wr(8'hAF);
      chk("R3 one param short", status, 8'h90);
      wr(8'h02);
      chk("R11 no result", status, 8'h80);
      chk("R11 irq unchanged", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_seek();
      logic [7:0] b;
      wr(8'h0F); wr(8'h01); wr(8'h2A);
      chk("R7 no result", status, 8'h80);
      chk("R7 irq raised", {7'b0, irq}, 8'h01);
      wr(8'h08);
      chk("R7 sense clears irq", {7'b0, irq}, 8'h00);
      rd(b);
      chk("R7 st0", b, 8'h21);
      rd(b);
      chk("R7 track", b, 8'h2A);
      chk("R4 after sense", status, 8'h80);
   endtask

   task automatic t_write();
      logic [7:0] b;
      logic [7:0] exp [7] = '{8'h02, 8'h00, 8'h00, 8'h11, 8'h00, 8'h03, 8'h02};
      wr(8'h45);
      wr(8'h02); wr(8'h11); wr(8'h00); wr(8'h03); wr(8'h02); wr(8'h12); wr(8'h1B);
      chk("R3 write not yet exec", {6'b0, phase_o}, 8'h01);
      wr(8'hFF);
      chk("R8 write exec status", status, 8'hB0);
      chk("R8 write exec phase", {6'b0, phase_o}, 8'h02);
      for (int k = 0; k < XLEN; k++) wr(8'hC0 + 8'(k));
      chk("R8 write result status", status, 8'hD0);
      chk("R8 write irq", {7'b0, irq}, 8'h01);
      for (int k = 0; k < 7; k++) begin
         rd(b);
         chk("R8 write result byte", b, exp[k]);
      end
      chk("R4 irq cleared", {7'b0, irq}, 8'h00);
      chk("R4 command again", status, 8'h80);
   endtask

   task automatic t_read();
      logic [7:0] b, e;
      logic [7:0] exp [7] = '{8'h01, 8'h00, 8'h00, 8'h05, 8'h01, 8'h07, 8'h02};
      wr(8'h06);
      wr(8'h01); wr(8'h05); wr(8'h01); wr(8'h07); wr(8'h02); wr(8'h12); wr(8'h1B); wr(8'hFF);
      chk("R8 read exec status", status, 8'hF0);
      wr(8'h55);
      chk("R10 exec wrong direction flagged", {7'b0, proto_err}, 8'h01);
      chk("R10 exec wrong direction phase", {6'b0, phase_o}, 8'h02);
      for (int k = 0; k < XLEN; k++) begin
         e = ((k % SECT) < 4) ? 8'hC8 + 8'(k % SECT) : 8'hC0 + 8'(k % SECT);
         rd(b);
         chk("R9 wrapped byte", b, e);
      end
      chk("R8 read irq", {7'b0, irq}, 8'h01);
      for (int k = 0; k < 7; k++) begin
         rd(b);
         chk("R8 read result byte", b, exp[k]);
      end
      chk("R4 irq cleared after read", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_proto();
      logic [7:0] b;
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      chk("R1 reset clears err", {7'b0, proto_err}, 8'h00);
      rd(b);
      chk("R10 command read flagged", {7'b0, proto_err}, 8'h01);
      chk("R10 command read ignored", status, 8'h80);
      wr(8'h10);
      wr(8'h18);
      chk("R10 result write ignored", {6'b0, phase_o}, 8'h03);
      rd(b);
      chk("R10 result byte kept", b, 8'h90);
      chk("R10 err sticky", {7'b0, proto_err}, 8'h01);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      summary();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_version();
      t_partid_lock();
      t_invalid();
      t_specify();
      t_seek();
      t_write();
      t_read();
      t_proto();
      summary();
      $finish;
   end

endmodule